// File: doc/BRIEF.md
# Digit-serial signed-digit to two's complement converter

This block turns a stream of signed binary digits, each in {-1, 0, +1} and carried as a pair of plus and minus bits, into an ordinary two's complement number. Digits arrive most significant first, at most one per clock. After each accepted digit the output register holds the exact two's complement value of every digit received since the last clear. No carry-propagate addition or subtraction over the word is ever needed, so the per-digit delay does not depend on the word length.

Two registers make this possible. The visible register holds the value so far. A shadow register holds that value minus one unit in the last place. A negative digit that would otherwise ripple a borrow through the word simply takes the shadow register's contents, with a bit appended. A producer of signed digits, such as a most-significant-first serial multiplier, drives the digit inputs and pulses the clear input before each new result.

Top module: `otf_converter`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, value reads zero.
- R2: A cycle with clear high sets value to zero on the next cycle, whatever digit_valid shows. A following digit -1 then gives all ones (-1).
- R3: A digit with digit_pos=1 and digit_neg=0 means +1, and value becomes twice its previous value plus one.
- R4: digit_pos=digit_neg=0 and digit_pos=digit_neg=1 both mean digit 0, and value becomes twice its previous value.
- R5: A digit with digit_pos=0 and digit_neg=1 means -1, and value becomes twice its previous value minus one, in the same single cycle as any other digit.
- R6: While digit_valid and clear are both low, value holds, whatever the digit bits show.
- R7: After k accepted digits d1..dk, with k at most DIGITS, value read as signed equals the sum of di * 2^(k-i), one cycle after dk is presented.
- R8: The shadow register always equals value minus one, modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Starts a new conversion; takes priority over a digit |
| digit_valid | input | 1 | A digit is presented this cycle |
| digit_pos | input | 1 | Plus bit of the signed digit |
| digit_neg | input | 1 | Minus bit of the signed digit |
| value | output | DIGITS+GUARD | Converted two's complement value |

## Verification
The assertions assume that the producer sends no more than DIGITS digits between clears, so the signed value never leaves the W-bit range. Beyond that count the upper bits are shifted out and the result wraps modulo 2^W. The bench always clears before each sequence, never sends more than DIGITS digits, and sweeps every sequence of DIGITS digits. It mixes both zero encodings and places idle cycles with arbitrary digit bits in the middle of a sequence.

// File: rtl/otf_pkg.sv
package otf_pkg;
  typedef enum logic [1:0] {
    DIG_ZERO = 2'd0,
    DIG_POS  = 2'd1,
    DIG_NEG  = 2'd2
  } sdigit_e;

  // plus/minus pair to signed digit; both-equal encodings read as zero
  function automatic sdigit_e decode_digit(input logic p, input logic n);
    if (p && !n) return DIG_POS;
    if (n && !p) return DIG_NEG;
    return DIG_ZERO;
  endfunction
endpackage

// File: rtl/otf_digit_decode.sv
module otf_digit_decode
  import otf_pkg::*;
(
  input  logic    pos_i,
  input  logic    neg_i,
  output sdigit_e digit_o,
  output logic    is_pos_o,
  output logic    is_neg_o,
  output logic    is_zero_o
);
  always_comb begin
    digit_o   = decode_digit(pos_i, neg_i);
    is_pos_o  = (digit_o == DIG_POS);
    is_neg_o  = (digit_o == DIG_NEG);
    is_zero_o = (digit_o == DIG_ZERO);
  end

  // R4: exactly one digit class is selected for any input pair
  always_comb begin
    a_r4_one_class: assert ($countones({is_pos_o, is_neg_o, is_zero_o}) == 1);
  end
endmodule

// File: rtl/otf_next_pair.sv
module otf_next_pair
  import otf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] qm_i,
  input  sdigit_e      digit_i,
  output logic [W-1:0] q_nxt_o,
  output logic [W-1:0] qm_nxt_o
);
  // shift left one place and put a new least significant bit in
  function automatic logic [W-1:0] append_bit(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  always_comb begin
    unique case (digit_i)
      DIG_POS: begin
        q_nxt_o  = append_bit(q_i, 1'b1);
        qm_nxt_o = append_bit(q_i, 1'b0);
      end
      DIG_NEG: begin
        q_nxt_o  = append_bit(qm_i, 1'b1);
        qm_nxt_o = append_bit(qm_i, 1'b0);
      end
      default: begin
        q_nxt_o  = append_bit(q_i, 1'b0);
        qm_nxt_o = append_bit(qm_i, 1'b1);
      end
    endcase
  end
endmodule

// File: rtl/otf_converter.sv
module otf_converter
  import otf_pkg::*;
#(
  parameter int DIGITS = 6,
  parameter int GUARD  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      digit_valid,
  input  logic                      digit_pos,
  input  logic                      digit_neg,
  output logic [DIGITS+GUARD-1:0]   value
);
  localparam int W = DIGITS + GUARD;
  localparam logic [W-1:0] ONE_ULP = W'(1);

  logic [W-1:0] q_r, qm_r, q_nxt, qm_nxt;
  sdigit_e      digit;
  logic         is_pos, is_neg, is_zero;
  logic         do_clear, take_digit;

  assign do_clear   = clear;
  assign take_digit = digit_valid && !clear;

  otf_digit_decode u_dec (
    .pos_i    (digit_pos),
    .neg_i    (digit_neg),
    .digit_o  (digit),
    .is_pos_o (is_pos),
    .is_neg_o (is_neg),
    .is_zero_o(is_zero)
  );

  otf_next_pair #(.W(W)) u_next (
    .q_i     (q_r),
    .qm_i    (qm_r),
    .digit_i (digit),
    .q_nxt_o (q_nxt),
    .qm_nxt_o(qm_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r  <= '0;
      qm_r <= '1;
    end else if (do_clear) begin
      q_r  <= '0;
      qm_r <= '1;
    end else if (take_digit) begin
      q_r  <= q_nxt;
      qm_r <= qm_nxt;
    end
  end

  assign value = q_r;

  // R8: shadow stays one unit below the visible value
  a_r8_shadow_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r - qm_r) == ONE_ULP);

  // R2: clear wins and yields zero
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> (value == '0));

  // R3: plus digit doubles and adds one
  a_r3_plus: assert property (@(posedge clk) disable iff (!rst_n)
    (take_digit && is_pos) |=> (value == W'($past(value) * 2 + 1)));

  // R4: zero digit doubles
  a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (take_digit && is_zero) |=> (value == W'($past(value) * 2)));

  // R5: minus digit doubles and subtracts one
  a_r5_minus: assert property (@(posedge clk) disable iff (!rst_n)
    (take_digit && is_neg) |=> (value == W'($past(value) * 2 - 1)));

  // R6: idle cycles leave the value alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!digit_valid && !clear) |=> $stable(value));
endmodule

// File: tb/otf_converter_tb.sv
module otf_converter_tb;
  localparam int DIGITS = 6;
  localparam int GUARD  = 1;
  localparam int W      = DIGITS + GUARD;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic         digit_valid = 1'b0;
  logic         digit_pos = 1'b0;
  logic         digit_neg = 1'b0;
  logic [W-1:0] value;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  otf_converter #(.DIGITS(DIGITS), .GUARD(GUARD)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .digit_valid(digit_valid),
    .digit_pos(digit_pos), .digit_neg(digit_neg), .value(value)
  );

  function automatic int as_signed(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(input string req, input int expected);
    n_checks++;
    if (as_signed(value) != expected) begin
      n_fail++;
      $display("FAIL %s: value=%0d expected=%0d", req, as_signed(value), expected);
    end
  endtask

  // drive for one cycle (called at a negedge), return at the next negedge
  task automatic cycle(input logic clr, input logic vld, input logic p, input logic n);
    clear = clr; digit_valid = vld; digit_pos = p; digit_neg = n;
    @(negedge clk);
    clear = 1'b0; digit_valid = 1'b0;
  endtask

  // send one signed digit d in {-1,0,1}; alt picks the (1,1) zero encoding
  task automatic send(input int d, input bit alt);
    if (d > 0)      cycle(1'b0, 1'b1, 1'b1, 1'b0);
    else if (d < 0) cycle(1'b0, 1'b1, 1'b0, 1'b1);
    else            cycle(1'b0, 1'b1, alt, alt);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: value=%0d expected=%0d", as_signed(value), 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int acc;
    @(negedge clk);
    check("R1", 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0);

    // exhaustive sweep of all DIGITS-long sequences (R3 R4 R5 R7)
    for (int s = 0; s < 729; s++) begin
      int rem;
      rem = s;
      cycle(1'b1, 1'b0, 1'b0, 1'b0);
      check("R2", 0);
      acc = 0;
      for (int i = 0; i < DIGITS; i++) begin
        int d;
        d = (rem % 3) - 1;
        rem = rem / 3;
        send(d, ((s + i) % 2) == 1);
        acc = acc * 2 + d;
        if (d > 0)      check("R3/R7", acc);
        else if (d < 0) check("R5/R7", acc);
        else            check("R4/R7", acc);
        if (i == 2 && (s % 5) == 0) begin
          cycle(1'b0, 1'b0, s[0], s[1]);  // idle with arbitrary digit bits
          check("R6", acc);
        end
      end
    end

    // clear takes priority over a simultaneous digit, then -1 gives all ones
    send(1, 1'b0); send(1, 1'b0);
    cycle(1'b1, 1'b1, 1'b1, 1'b0);
    check("R2", 0);
    send(-1, 1'b0);
    check("R2", -1);
    send(-1, 1'b0);
    check("R5", -3);

    // reset mid-stream
    send(1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0);
    send(-1, 1'b0);
    check("R5", -1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule